// File: doc/BRIEF.md
# Privilege-Checked Virtual Segment Decoder

This block takes a 32-bit virtual address together with the current privilege level (kernel, supervisor or user), an error-level flag and a read/write indication, and sorts the access into one of three outcomes. The address may be unmapped, in which case a physical address is formed by a fixed offset and full read/write permission is granted. It may need translation, in which case it is flagged for the TLB. Or it may be an address error, in which case a load or store error class is reported. The top three address bits pick one of five fixed segments; the privilege level decides whether that segment may be touched.

Requests arrive on a valid/ready stream and results leave on a valid/ready stream. With `REG_OUT` = 0 the decode is purely combinational: the result is valid in the same cycle as the request, `out_valid` follows `in_valid` and `in_ready` follows `out_ready`. With `REG_OUT` = 1 (default) a single output register stage sits behind the decode. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. A result is consumed on an edge where `out_valid` and `out_ready` are both high. While a result waits with `out_ready` low, it holds unchanged and no new request is taken.

Top module: `vseg_decoder`

## Requirements
- R1: With the error-level flag clear, addresses 0x00000000–0x7FFFFFFF report mapped (TLB) with no error, in every privilege level.
- R2: With the error-level flag set, addresses 0x00000000–0x7FFFFFFF report unmapped with a physical address equal to the virtual address. The flag has no effect on addresses at or above 0x80000000.
- R3: In kernel level, addresses 0x80000000–0x9FFFFFFF report unmapped with physical address = address − 0x80000000.
- R4: In kernel level, addresses 0xA0000000–0xBFFFFFFF report unmapped with physical address = address − 0xA0000000.
- R5: Addresses 0xC0000000–0xDFFFFFFF report mapped in kernel or supervisor level and an address error in user level.
- R6: Addresses 0xE0000000–0xFFFFFFFF report mapped in kernel level only and an address error otherwise.
- R7: Addresses 0x80000000–0xBFFFFFFF report an address error in supervisor and user level.
- R8: Exactly one of mapped, unmapped and address error is high for each result. On an error, `out_err_store` is 1 for a write and 0 for a read. `out_err_store` is 0 whenever there is no error.
- R9: Both permission outputs are 1 for an unmapped result and 0 otherwise. `out_paddr` is 0 unless the result is unmapped.
- R10: Privilege encoding on `in_mode`: 0 kernel, 1 supervisor, 2 user. Code 3 behaves exactly as user.
- R11: With `REG_OUT` = 1: `in_ready` = !`out_valid` || `out_ready`, and a result stalled by `out_ready` low stays unchanged until it is taken. With `REG_OUT` = 0: the result is valid in the request's own cycle.
- R12: During and right after reset, `out_valid` is 0 in the registered variant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_addr | input | 32 | Virtual address |
| in_mode | input | 2 | Privilege: 0 kernel, 1 supervisor, 2/3 user |
| in_erl | input | 1 | Error-level flag |
| in_write | input | 1 | 1 for a store access, 0 for a load |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream takes the result |
| out_mapped | output | 1 | Address must be translated by the TLB |
| out_unmapped | output | 1 | Address translated by fixed offset |
| out_addr_err | output | 1 | Access not allowed at this privilege |
| out_err_store | output | 1 | Error class: 1 store, 0 load |
| out_perm_rd | output | 1 | Read permitted (unmapped results) |
| out_perm_wr | output | 1 | Write permitted (unmapped results) |
| out_paddr | output | 32 | Physical address for unmapped results |

## Verification
A wrong segment boundary or a wrong privilege test shows at the ports as the wrong outcome flag or a wrong physical address. It appears in the very cycle of the request for the combinational variant and one cycle later for the registered one. A wrong valid state in the output register shows up differently. It can surface as a result that vanishes or changes under back-pressure, or as `in_ready` disagreeing with `out_ready`. These faults are visible in the same cycle the stall begins or on the following edge. The bench runs both variants side by side against a behavioural model, with a queue of pending results for the registered one.

// File: rtl/vsd_pkg.sv
package vsd_pkg;
  localparam int VA_W = 32;
  localparam int SEG_BITS = 3;

  typedef enum logic [1:0] {
    PRIV_KERN  = 2'd0,
    PRIV_SUPV  = 2'd1,
    PRIV_USER  = 2'd2,
    PRIV_USER3 = 2'd3
  } priv_e;

  typedef enum logic [2:0] {
    SEG_LOW_USER,
    SEG_KDIRECT_A,
    SEG_KDIRECT_B,
    SEG_SUPV_MAP,
    SEG_KERN_MAP
  } seg_e;

  typedef struct packed {
    logic            mapped;
    logic            unmapped;
    logic            err;
    logic            err_store;
    logic            perm_rd;
    logic            perm_wr;
    logic [VA_W-1:0] paddr;
  } vsd_res_t;
endpackage

// File: rtl/vsd_seg_classify.sv
module vsd_seg_classify
  import vsd_pkg::*;
(
  input  logic [SEG_BITS-1:0] va_top,
  output seg_e                seg
);
  always_comb begin
    if (!va_top[SEG_BITS-1]) begin
      seg = SEG_LOW_USER;
    end else begin
      unique case (va_top[SEG_BITS-2:0])
        2'b00:   seg = SEG_KDIRECT_A;
        2'b01:   seg = SEG_KDIRECT_B;
        2'b10:   seg = SEG_SUPV_MAP;
        default: seg = SEG_KERN_MAP;
      endcase
    end
  end
endmodule

// File: rtl/vsd_priv_check.sv
module vsd_priv_check
  import vsd_pkg::*;
(
  input  seg_e            seg,
  input  logic [1:0]      mode,
  input  logic            erl,
  input  logic            wr,
  input  logic [VA_W-1:0] va,
  output vsd_res_t        res
);
  localparam int OFS_W = VA_W - SEG_BITS;

  logic is_kern;
  logic is_supv;
  logic allow;
  logic direct;

  assign is_kern = (mode == PRIV_KERN);
  assign is_supv = (mode == PRIV_SUPV);

  always_comb begin
    allow  = 1'b0;
    direct = 1'b0;
    unique case (seg)
      SEG_LOW_USER: begin
        allow  = 1'b1;
        direct = erl;
      end
      SEG_KDIRECT_A, SEG_KDIRECT_B: begin
        allow  = is_kern;
        direct = 1'b1;
      end
      SEG_SUPV_MAP: allow = is_kern | is_supv;
      default:      allow = is_kern;
    endcase
  end

  always_comb begin
    res           = '0;
    res.err       = ~allow;
    res.err_store = ~allow & wr;
    res.unmapped  = allow & direct;
    res.mapped    = allow & ~direct;
    res.perm_rd   = res.unmapped;
    res.perm_wr   = res.unmapped;
    if (res.unmapped) begin
      if (seg == SEG_LOW_USER) res.paddr = va;
      else                     res.paddr = {{SEG_BITS{1'b0}}, va[OFS_W-1:0]};
    end
  end
endmodule

// File: rtl/vsd_out_stage.sv
module vsd_out_stage
  import vsd_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_valid,
  output logic     in_ready,
  input  vsd_res_t in_res,
  output logic     out_valid,
  input  logic     out_ready,
  output vsd_res_t out_res
);
  generate
    if (REG_OUT) begin : g_reg
      logic     vld_q;
      vsd_res_t res_q;

      assign in_ready  = ~vld_q | out_ready;
      assign out_valid = vld_q;
      assign out_res   = res_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
          res_q <= '0;
        end else if (in_ready) begin
          vld_q <= in_valid;
          if (in_valid) res_q <= in_res;
        end
      end

      p_hold_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_res)));
      p_ready_rule_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);
    end else begin : g_comb
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_res   = in_res;
    end
  endgenerate
endmodule

// File: rtl/vseg_decoder.sv
module vseg_decoder
  import vsd_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [VA_W-1:0] in_addr,
  input  logic [1:0]      in_mode,
  input  logic            in_erl,
  input  logic            in_write,
  output logic            out_valid,
  input  logic            out_ready,
  output logic            out_mapped,
  output logic            out_unmapped,
  output logic            out_addr_err,
  output logic            out_err_store,
  output logic            out_perm_rd,
  output logic            out_perm_wr,
  output logic [VA_W-1:0] out_paddr
);
  seg_e     seg;
  vsd_res_t dec;
  vsd_res_t res_o;

  vsd_seg_classify u_classify (
    .va_top (in_addr[VA_W-1 -: SEG_BITS]),
    .seg    (seg)
  );

  vsd_priv_check u_check (
    .seg  (seg),
    .mode (in_mode),
    .erl  (in_erl),
    .wr   (in_write),
    .va   (in_addr),
    .res  (dec)
  );

  vsd_out_stage #(.REG_OUT(REG_OUT)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_res    (dec),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_res   (res_o)
  );

  assign out_mapped    = res_o.mapped;
  assign out_unmapped  = res_o.unmapped;
  assign out_addr_err  = res_o.err;
  assign out_err_store = res_o.err_store;
  assign out_perm_rd   = res_o.perm_rd;
  assign out_perm_wr   = res_o.perm_wr;
  assign out_paddr     = res_o.paddr;

  p_one_outcome_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot({out_mapped, out_unmapped, out_addr_err}));
  p_perm_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_unmapped) |-> (out_perm_rd && out_perm_wr));
  p_user_high_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_addr[VA_W-1] && in_mode[1] &&
     in_addr[VA_W-2:VA_W-3] != 2'b11) |-> dec.err);
  p_erl_identity_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_erl && !in_addr[VA_W-1]) |-> (dec.unmapped && dec.paddr == in_addr));
endmodule

// File: tb/test_vseg_decoder.sv
module test_vseg_decoder;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, in_valid, out_ready, in_erl, in_write;
  logic [1:0]  in_mode;
  logic [31:0] in_addr;

  logic r_in_ready, r_out_valid, r_map, r_unm, r_err, r_est, r_prd, r_pwr;
  logic [31:0] r_pa;
  logic c_in_ready, c_out_valid, c_map, c_unm, c_err, c_est, c_prd, c_pwr;
  logic [31:0] c_pa;

  int checks = 0;
  int errors = 0;
  logic [37:0] expq[$];
  string       tagq[$];

  vseg_decoder #(.REG_OUT(1'b1)) i_vseg_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(r_in_ready),
    .in_addr(in_addr), .in_mode(in_mode), .in_erl(in_erl), .in_write(in_write),
    .out_valid(r_out_valid), .out_ready(out_ready), .out_mapped(r_map),
    .out_unmapped(r_unm), .out_addr_err(r_err), .out_err_store(r_est),
    .out_perm_rd(r_prd), .out_perm_wr(r_pwr), .out_paddr(r_pa));

  vseg_decoder #(.REG_OUT(1'b0)) i_vseg_decoder_comb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(c_in_ready),
    .in_addr(in_addr), .in_mode(in_mode), .in_erl(in_erl), .in_write(in_write),
    .out_valid(c_out_valid), .out_ready(out_ready), .out_mapped(c_map),
    .out_unmapped(c_unm), .out_addr_err(c_err), .out_err_store(c_est),
    .out_perm_rd(c_prd), .out_perm_wr(c_pwr), .out_paddr(c_pa));

  function automatic logic [37:0] model(input logic [31:0] a, input logic [1:0] m,
                                        input logic e, input logic w);
    bit k = (m == 2'd0);
    bit s = (m == 2'd1);
    logic mp = 1'b0, um = 1'b0, er = 1'b0;
    logic [31:0] pa = 32'h0;
    if (a < 32'h8000_0000) begin
      if (e) begin um = 1'b1; pa = a; end else mp = 1'b1;
    end else if (a < 32'hA000_0000) begin
      if (k) begin um = 1'b1; pa = a - 32'h8000_0000; end else er = 1'b1;
    end else if (a < 32'hC000_0000) begin
      if (k) begin um = 1'b1; pa = a - 32'hA000_0000; end else er = 1'b1;
    end else if (a < 32'hE000_0000) begin
      if (k || s) mp = 1'b1; else er = 1'b1;
    end else begin
      if (k) mp = 1'b1; else er = 1'b1;
    end
    return {mp, um, er, er & w, um, um, pa};
  endfunction

  function automatic string tag(input logic [31:0] a, input logic [1:0] m, input logic e);
    string t;
    if (a < 32'h8000_0000) t = e ? "R2" : "R1";
    else if (m == 2'd3) t = "R10";
    else if (a < 32'hC000_0000) begin
      if (m != 2'd0) t = "R7";
      else t = (a < 32'hA000_0000) ? "R3/R9" : "R4/R9";
    end else if (a < 32'hE000_0000) t = "R5";
    else t = "R6";
    if (a >= 32'h8000_0000 && e) t = {t, "/R2"};
    return {t, "/R8"};
  endfunction

  task automatic check(input bit ok, input string t, input logic [37:0] act, input logic [37:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", t, act, exp, $time);
    end
  endtask

  task automatic step(input logic v, input logic rdy, input logic [31:0] a,
                      input logic [1:0] m, input logic e, input logic w);
    logic [37:0] exp, ract, cact;
    string t;
    @(negedge clk);
    in_valid = v; out_ready = rdy; in_addr = a; in_mode = m; in_erl = e; in_write = w;
    #1;
    exp  = model(a, m, e, w);
    t    = tag(a, m, e);
    cact = {c_map, c_unm, c_err, c_est, c_prd, c_pwr, c_pa};
    ract = {r_map, r_unm, r_err, r_est, r_prd, r_pwr, r_pa};
    // R11: combinational variant is valid in the request's cycle
    check(c_out_valid == v && c_in_ready == rdy, "R11 comb handshake",
          {36'h0, c_out_valid, c_in_ready}, {36'h0, v, rdy});
    if (v) check(cact == exp, {t, " comb"}, cact, exp);
    // R11: registered variant ready rule and occupancy
    check(r_in_ready == (expq.size() == 0 || rdy), "R11 ready rule",
          {37'h0, r_in_ready}, {37'h0, (expq.size() == 0 || rdy)});
    check(r_out_valid == (expq.size() != 0), "R11 occupancy",
          {37'h0, r_out_valid}, {37'h0, expq.size() != 0});
    if (r_out_valid && rdy && expq.size() != 0) begin
      check(ract == expq[0], {tagq[0], " reg"}, ract, expq[0]);
      void'(expq.pop_front());
      void'(tagq.pop_front());
    end
    if (v && r_in_ready) begin
      expq.push_back(exp);
      tagq.push_back(t);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] pts [10] = '{32'h0000_1234, 32'h7FFF_FFFF, 32'h8000_0000, 32'h9FFF_FFFF,
                              32'hA000_0010, 32'hBFFF_FFFF, 32'hC000_0000, 32'hDFFF_FFFF,
                              32'hE000_0000, 32'hFFFF_FFFF};
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_addr = '0;
    in_mode = '0; in_erl = 1'b0; in_write = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12: nothing valid during reset
    check(r_out_valid == 1'b0, "R12 during reset", {37'h0, r_out_valid}, 38'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(r_out_valid == 1'b0, "R12 after reset", {37'h0, r_out_valid}, 38'h0);
    check(r_in_ready == 1'b1, "R12 ready after reset", {37'h0, r_in_ready}, 38'h1);
    for (int i = 0; i < 10; i++)
      for (int m = 0; m < 4; m++)
        for (int e = 0; e < 2; e++)
          for (int w = 0; w < 2; w++)
            step(1'b1, 1'b1, pts[i], m[1:0], e[0], w[0]);
    for (int n = 0; n < 4000; n++)
      step($urandom_range(3, 0) != 0, $urandom_range(9, 0) < 6, $urandom,
           2'($urandom_range(3, 0)), 1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)));
    for (int n = 0; n < 3; n++) step(1'b0, 1'b1, 32'h0, 2'd0, 1'b0, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule